// File: doc/BRIEF.md
# Configurable Interrupt Source Bank

This block gathers up to 32 interrupt inputs into one request line. Software sets it up through a small register window. For each source, one bit selects level or edge sensing and another selects the active polarity. Every raw input passes through a two-stage synchronizer. After that, the block latches a pending bit. A level-sensed bit tracks the active state of its input. An edge-sensed bit is captured on an inactive-to-active transition and stays pending until software acknowledges it.

Software can raise a pending bit or drop it by writing ones to two separate write-only locations. The request output is raised whenever a pending bit has its enable bit set. The offsets are local to one bank. A system that has several banks places them 0x18 bytes apart, and the source number splits into bank (number / 32) and bit (number mod 32) outside this block.

The register decoder turns each offset into one of seven named selections: STATUS, ENABLE, SET, CLEAR, POLAR, TRIG and NONE. There are no sequential states. Each cell's pending bit moves between idle and pending. The transitions are SET (forced), CLEAR (acknowledged), RISE (an edge in edge mode) and FOLLOW (the level in level mode).

Top module: `irqb_bank`

## Requirements
- R1: After reset, the enable and trigger-select registers read 0, the polarity register reads all ones, the status register reads 0, and irq_o is low.
- R2: Offset 0x04 (enable), 0x10 (polarity) and 0x14 (trigger select) each read back the last value written to them.
- R3: Reading offset 0x08, offset 0x0C or any unmapped or unaligned offset returns 0. Writing offset 0x00 (status) has no effect on the status bits.
- R4: Each input is synchronized by two flops. In level mode, a change at the input first shows in the status bit after the third rising clock edge that samples it.
- R5: A polarity bit of 1 makes a high input active. A polarity bit of 0 makes a low input active.
- R6: When its trigger-select bit is 0 (level mode), a status bit equals the polarity-adjusted synchronized input on every cycle that has no set or clear write to that bit.
- R7: When its trigger-select bit is 1 (edge mode), a status bit becomes 1 after an inactive-to-active transition of the synchronized input. It then stays 1, whatever the input does, until it is cleared.
- R8: Writing to offset 0x0C clears each status bit whose data bit is 1 and leaves each status bit whose data bit is 0 unchanged.
- R9: Writing to offset 0x08 forces each status bit whose data bit is 1 to pending. A set takes priority over a clear and over input activity on the same bit.
- R10: irq_o is high exactly when the bitwise AND of status (offset 0x00) and enable (offset 0x04) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw interrupt inputs, asynchronous |
| reg_addr_i | input | OFS_W | Byte offset within the bank |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NSRC | Write data |
| reg_rdata_o | output | NSRC | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined request |

## Verification
Sensing is tried with a single isolated bit, a low-active level input, a one-cycle pulse in edge mode, and a steady high input after an acknowledge. Together these separate synchronizer latency, polarity inversion, edge capture and level tracking. Set and clear writes are applied with patterns that mix ones and zeros, so a bit that was left alone shows whether the write touched it. A long run of random inputs and register writes is compared on every cycle against a behavioural model of the whole register view and the request line.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

    localparam int OFS_W_DEF = 5;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_ENABLE,
        SEL_SET,
        SEL_CLEAR,
        SEL_POLAR,
        SEL_TRIG,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W_DEF-1:0] ofs);
        reg_sel_e sel;
        unique case (ofs)
            5'h00:   sel = SEL_STATUS;
            5'h04:   sel = SEL_ENABLE;
            5'h08:   sel = SEL_SET;
            5'h0C:   sel = SEL_CLEAR;
            5'h10:   sel = SEL_POLAR;
            5'h14:   sel = SEL_TRIG;
            default: sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/irqb_sync.sv
module irqb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqb_cell.sv
module irqb_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    logic act;
    logic prev_q;
    logic pend_q;
    logic rise;

    assign act  = pol_i ? sync_i : ~sync_i;
    assign rise = act & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= act;
            if (set_i)       pend_q <= 1'b1;
            else if (clr_i)  pend_q <= 1'b0;
            else if (edge_i) pend_q <= pend_q | rise;
            else             pend_q <= act;
        end
    end

    assign pend_o = pend_q;

    AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q); // R9
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_q); // R8
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && pend_q && !clr_i) |=> pend_q); // R7
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !set_i && !clr_i) |=> (pend_q == $past(act))); // R6
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank
    import irqb_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int OFS_W = OFS_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [OFS_W-1:0] reg_addr_i,
    input  logic             reg_we_i,
    input  logic [NSRC-1:0]  reg_wdata_i,
    output logic [NSRC-1:0]  reg_rdata_o,
    output logic             irq_o
);
    localparam int SYNC_STAGES = 2;

    reg_sel_e        sel;
    logic [NSRC-1:0] enable_q;
    logic [NSRC-1:0] polar_q;
    logic [NSRC-1:0] trig_q;
    logic [NSRC-1:0] sync_vec;
    logic [NSRC-1:0] status_vec;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    assign sel = decode_ofs(reg_addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            polar_q  <= '1;
            trig_q   <= '0;
        end else if (reg_we_i) begin
            if (sel == SEL_ENABLE) enable_q <= reg_wdata_i;
            if (sel == SEL_POLAR)  polar_q  <= reg_wdata_i;
            if (sel == SEL_TRIG)   trig_q   <= reg_wdata_i;
        end
    end

    assign set_vec = (reg_we_i && sel == SEL_SET)   ? reg_wdata_i : '0;
    assign clr_vec = (reg_we_i && sel == SEL_CLEAR) ? reg_wdata_i : '0;

    irqb_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_i),
        .q     (sync_vec)
    );

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_cell
            irqb_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .sync_i (sync_vec[i]),
                .pol_i  (polar_q[i]),
                .edge_i (trig_q[i]),
                .set_i  (set_vec[i]),
                .clr_i  (clr_vec[i]),
                .pend_o (status_vec[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata_o = status_vec;
            SEL_ENABLE: reg_rdata_o = enable_q;
            SEL_POLAR:  reg_rdata_o = polar_q;
            SEL_TRIG:   reg_rdata_o = trig_q;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(status_vec & enable_q);

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq_o); // R10
    AST_NO_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec == '0) |-> !irq_o); // R10
endmodule

// File: tb/irqb_bank_test.sv
module irqb_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [4:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [31:0] m_s1, m_s2, m_prev, m_stat, m_en, m_pol, m_trig;

    always #4 clk = ~clk;

    irqb_bank uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            m_en = '0; m_pol = '1; m_trig = '0;
        end else begin
            logic [31:0] act;
            logic [31:0] sv;
            logic [31:0] cv;
            act = '0;
            for (int i = 0; i < 32; i++) act[i] = m_pol[i] ? m_s2[i] : !m_s2[i];
            sv = (we && addr == 5'h08) ? wd : '0;
            cv = (we && addr == 5'h0C) ? wd : '0;
            for (int i = 0; i < 32; i++) begin
                if (sv[i])          m_stat[i] = 1'b1;
                else if (cv[i])     m_stat[i] = 1'b0;
                else if (m_trig[i]) m_stat[i] = m_stat[i] | (act[i] & !m_prev[i]);
                else                m_stat[i] = act[i];
            end
            m_prev = act;
            m_s2 = m_s1;
            m_s1 = src;
            if (we && addr == 5'h04) m_en   = wd;
            if (we && addr == 5'h10) m_pol  = wd;
            if (we && addr == 5'h14) m_trig = wd;
        end
    end

    function automatic logic [31:0] model_rd(input logic [4:0] a);
        case (a)
            5'h00:   return m_stat;
            5'h04:   return m_en;
            5'h10:   return m_pol;
            5'h14:   return m_trig;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk(cur_req, {31'd0, irq}, {31'd0, |(m_stat & m_en)});
        chk(cur_req, rd, model_rd(addr));
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; we = 1'b1; wd = d;
        step();
        we = 1'b0; wd = '0;
    endtask

    task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rd, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        rchk("R1", 5'h00, 32'h0);
        rchk("R1", 5'h04, 32'h0);
        rchk("R1", 5'h10, 32'hFFFF_FFFF);
        rchk("R1", 5'h14, 32'h0);
        chk("R1", {31'd0, irq}, 32'd0);

        // R2 read-back
        cur_req = "R2";
        wr(5'h04, 32'hA5A5_0F0F); rchk("R2", 5'h04, 32'hA5A5_0F0F);
        wr(5'h14, 32'h1234_5678); rchk("R2", 5'h14, 32'h1234_5678);
        wr(5'h10, 32'h0F0F_F0F0); rchk("R2", 5'h10, 32'h0F0F_F0F0);
        wr(5'h04, 32'h0); wr(5'h14, 32'h0); wr(5'h10, 32'hFFFF_FFFF);
        repeat (4) step();

        // R3 write-only and unmapped reads, status not writable
        cur_req = "R3";
        wr(5'h00, 32'hFFFF_FFFF);
        rchk("R3", 5'h00, 32'h0);
        rchk("R3", 5'h08, 32'h0);
        rchk("R3", 5'h0C, 32'h0);
        rchk("R3", 5'h18, 32'h0);
        rchk("R3", 5'h02, 32'h0);

        // R4 synchronizer latency, level mode
        cur_req = "R4";
        addr = 5'h00;
        step();
        src = 32'h0000_0008;
        step(); chk("R4", {31'd0, rd[3]}, 32'd0);
        step(); chk("R4", {31'd0, rd[3]}, 32'd0);
        step(); chk("R4", {31'd0, rd[3]}, 32'd1);

        // R6 level tracking drops with input
        cur_req = "R6";
        src = 32'h0;
        repeat (3) step();
        chk("R6", rd, 32'h0);

        // R5 low-active polarity
        cur_req = "R5";
        wr(5'h10, 32'hFFFF_FFEF);
        repeat (3) step();
        rchk("R5", 5'h00, 32'h0000_0010);
        src = 32'h0000_0010;
        repeat (4) step();
        rchk("R5", 5'h00, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        src = 32'h0;
        repeat (4) step();

        // R7 edge capture of a one-cycle pulse
        cur_req = "R7";
        wr(5'h14, 32'h0000_FF00);
        addr = 5'h00;
        src = 32'h0000_0100;
        step();
        src = 32'h0;
        repeat (6) step();
        chk("R7", rd, 32'h0000_0100);

        // R8 clear with zero bits leaves others, clear with one drops
        cur_req = "R8";
        wr(5'h0C, 32'h0000_0200);
        rchk("R8", 5'h00, 32'h0000_0100);
        wr(5'h0C, 32'h0000_0100);
        rchk("R8", 5'h00, 32'h0);

        // R7 steady high does not re-arm after clear
        cur_req = "R7";
        src = 32'h0000_0400;
        repeat (4) step();
        rchk("R7", 5'h00, 32'h0000_0400);
        wr(5'h0C, 32'h0000_0400);
        repeat (3) step();
        rchk("R7", 5'h00, 32'h0);
        src = 32'h0;
        repeat (3) step();

        // R9 set forces pending, persists in edge mode
        cur_req = "R9";
        wr(5'h08, 32'h0000_2000);
        repeat (2) step();
        rchk("R9", 5'h00, 32'h0000_2000);

        // R10 masking
        cur_req = "R10";
        chk("R10", {31'd0, irq}, 32'd0);
        wr(5'h04, 32'h0000_0001);
        chk("R10", {31'd0, irq}, 32'd0);
        wr(5'h04, 32'h0000_2000);
        chk("R10", {31'd0, irq}, 32'd1);
        wr(5'h0C, 32'h0000_2000);
        chk("R10", {31'd0, irq}, 32'd0);

        // random mixed traffic compared every cycle
        for (int n = 0; n < 2000; n++) begin
            logic [2:0] pick;
            src = $urandom;
            pick = 3'($urandom % 7);
            addr = (pick == 3'd6) ? 5'h18 : {pick, 2'b00};
            we = ($urandom % 4) == 0;
            wd = $urandom;
            step();
        end
        we = 1'b0;
        step();
        finish_run();
    end
endmodule